// File: doc/BRIEF.md
# Repetition Counter with Deferred Reload

This block sits beside a main timer and divides its overflow events. Each overflow (one autoreload match of the main timer) steps an 8-bit down counter. An overflow that finds the counter at zero is an underflow. It produces an update event, and the counter reloads from the repetition value. The update event is a single-cycle pulse. The neighbouring timer logic uses the same pulse to commit its own preloaded period and compare values. The pulse also sets a sticky flag that can drive an interrupt.

Software writes the repetition value through a one-stage transfer into the counting logic. A sticky acknowledge flag rises when the value has arrived. In immediate mode the written value becomes the active reload value as soon as it arrives. In preload mode the value waits as a pending value and becomes active only at the next underflow, and that underflow already reloads with it. In both modes a write never disturbs the count that is running. Starting the main timer, or restarting it on a timeout trigger, loads the counter from the active reload value.

Top module: `repeat_cnt`

## Requirements
- R1: After reset the count is 0, `update_o`, `ue_flag_o`, `repok_o` and `irq_o` are 0, and the active reload value is 0.
- R2: An overflow (`ovf_i` high at a clock edge) with a nonzero count and no load request lowers the count by exactly one, with no update pulse.
- R3: An overflow with the count at zero and no load request raises `update_o` for exactly one cycle after that edge, and the count takes the reload value in the same edge.
- R4: With a reload value of zero, every overflow produces an update pulse and the count stays 0.
- R5: With `preload_i` = 1, a written value is held pending. A start still loads the previous active value. The next underflow reloads the count with the pending value, and that value then becomes the active one.
- R6: With `preload_i` = 0, a written value becomes the active reload value once transferred. The next start or underflow loads it.
- R7: `start_i` or `restart_i` loads the count from the active reload value. A load takes priority over a simultaneous overflow and produces no update pulse.
- R8: `ue_flag_o` is set by each update pulse and stays set until `ue_clr_i`. When a set and a clear fall in the same cycle, the set wins.
- R9: `irq_o` is high exactly when `ue_flag_o` and `ue_ie_i` are both high.
- R10: `repok_o` rises on the second clock edge after a write is sampled, stays set until `repok_clr_i`, and a new arrival wins over a simultaneous clear.
- R11: Without an overflow, start or restart, the count holds its value, including across writes of the repetition value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| preload_i | input | 1 | 1: deferred reload value; 0: immediate |
| start_i | input | 1 | Main timer start, loads the count |
| restart_i | input | 1 | Timeout restart, loads the count |
| ovf_i | input | 1 | One-cycle main timer overflow |
| rep_wr_i | input | 1 | Repetition value write strobe |
| rep_wdata_i | input | REP_W | Written repetition value |
| ue_clr_i | input | 1 | Clear for the update flag |
| ue_ie_i | input | 1 | Interrupt enable for the update flag |
| repok_clr_i | input | 1 | Clear for the write acknowledge flag |
| rep_cnt_o | output | REP_W | Current repetition count |
| update_o | output | 1 | One-cycle update pulse, commits preloaded registers |
| ue_flag_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Update interrupt |
| repok_o | output | 1 | Sticky write acknowledge flag |

## Verification
The properties assume that `ovf_i` is a single-cycle strobe from the main timer. They also assume that a second write is issued only after the acknowledge of the first, because the write stage holds only one value. The bench drives every input on the falling clock edge. It keeps overflows to single-cycle pulses and waits for `repok_o` after each write before the next step. It applies collisions, such as a restart together with an overflow or a flag clear together with an update, only where the requirements define the outcome.

// File: rtl/repeat_cnt_pkg.sv
package repeat_cnt_pkg;
  localparam int unsigned REP_W_DEF = 8;

  typedef struct packed {
    logic valid;
    logic [REP_W_DEF-1:0] value;
  } rep_xfer_t;
endpackage

// File: rtl/repeat_cnt_xfer.sv
module repeat_cnt_xfer #(
  parameter int unsigned REP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REP_W-1:0] wdata_i,
  output logic             xfer_v_o,
  output logic [REP_W-1:0] xfer_val_o
);
  // single stage standing in for the bus-to-counter crossing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_v_o   <= 1'b0;
      xfer_val_o <= '0;
    end else begin
      xfer_v_o <= wr_i;
      if (wr_i) xfer_val_o <= wdata_i;
    end
  end
endmodule

// File: rtl/repeat_cnt_reload.sv
module repeat_cnt_reload #(
  parameter int unsigned REP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             preload_i,
  input  logic             xfer_v_i,
  input  logic [REP_W-1:0] xfer_val_i,
  input  logic             upd_i,
  output logic [REP_W-1:0] rld_active_o,
  output logic [REP_W-1:0] rld_next_o
);
  logic [REP_W-1:0] pend_q;
  logic             pend_v_q;

  // value used by an underflow: pending one if deferred, else active
  assign rld_next_o = (preload_i && pend_v_q) ? pend_q : rld_active_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_active_o <= '0;
      pend_q       <= '0;
      pend_v_q     <= 1'b0;
    end else begin
      if (upd_i) rld_active_o <= rld_next_o;
      if (xfer_v_i) begin
        if (preload_i) begin
          pend_q   <= xfer_val_i;
          pend_v_q <= 1'b1;
        end else begin
          rld_active_o <= xfer_val_i;
          pend_v_q     <= 1'b0;
        end
      end else if (upd_i) begin
        pend_v_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/repeat_cnt_down.sv
module repeat_cnt_down #(
  parameter int unsigned REP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             ovf_i,
  input  logic [REP_W-1:0] rld_active_i,
  input  logic [REP_W-1:0] rld_next_i,
  output logic             upd_o,
  output logic [REP_W-1:0] cnt_o,
  output logic             update_o
);
  assign upd_o = ovf_i && !load_i && (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      update_o <= 1'b0;
    end else begin
      update_o <= upd_o;
      if (load_i)     cnt_o <= rld_active_i;
      else if (upd_o) cnt_o <= rld_next_i;
      else if (ovf_i) cnt_o <= cnt_o - 1'b1;
    end
  end
endmodule

// File: rtl/repeat_cnt_sticky.sv
module repeat_cnt_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/repeat_cnt.sv
module repeat_cnt
  import repeat_cnt_pkg::*;
#(
  parameter int unsigned REP_W = REP_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             preload_i,
  input  logic             start_i,
  input  logic             restart_i,
  input  logic             ovf_i,
  input  logic             rep_wr_i,
  input  logic [REP_W-1:0] rep_wdata_i,
  input  logic             ue_clr_i,
  input  logic             ue_ie_i,
  input  logic             repok_clr_i,
  output logic [REP_W-1:0] rep_cnt_o,
  output logic             update_o,
  output logic             ue_flag_o,
  output logic             irq_o,
  output logic             repok_o
);
  logic             xfer_v;
  logic [REP_W-1:0] xfer_val;
  logic [REP_W-1:0] rld_active, rld_next;
  logic             upd;
  logic             load;

  assign load = start_i || restart_i;

  repeat_cnt_xfer #(.REP_W(REP_W)) i_xfer (
    .clk_i, .rst_ni,
    .wr_i       (rep_wr_i),
    .wdata_i    (rep_wdata_i),
    .xfer_v_o   (xfer_v),
    .xfer_val_o (xfer_val)
  );

  repeat_cnt_reload #(.REP_W(REP_W)) i_reload (
    .clk_i, .rst_ni,
    .preload_i,
    .xfer_v_i     (xfer_v),
    .xfer_val_i   (xfer_val),
    .upd_i        (upd),
    .rld_active_o (rld_active),
    .rld_next_o   (rld_next)
  );

  repeat_cnt_down #(.REP_W(REP_W)) i_down (
    .clk_i, .rst_ni,
    .load_i       (load),
    .ovf_i,
    .rld_active_i (rld_active),
    .rld_next_i   (rld_next),
    .upd_o        (upd),
    .cnt_o        (rep_cnt_o),
    .update_o
  );

  repeat_cnt_sticky i_ue_flag (
    .clk_i, .rst_ni,
    .set_i  (upd),
    .clr_i  (ue_clr_i),
    .flag_o (ue_flag_o)
  );

  repeat_cnt_sticky i_repok_flag (
    .clk_i, .rst_ni,
    .set_i  (xfer_v),
    .clr_i  (repok_clr_i),
    .flag_o (repok_o)
  );

  assign irq_o = ue_flag_o && ue_ie_i;
endmodule

// File: rtl/repeat_cnt_chk.sv
module repeat_cnt_chk #(
  parameter int unsigned REP_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             restart_i,
  input logic             ovf_i,
  input logic             rep_wr_i,
  input logic             ue_clr_i,
  input logic [REP_W-1:0] rep_cnt_o,
  input logic             update_o,
  input logic             ue_flag_o,
  input logic             irq_o,
  input logic             repok_o
);
  assert_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i && !start_i && !restart_i && rep_cnt_o != '0
      |=> rep_cnt_o == $past(rep_cnt_o) - 1'b1);

  assert_update_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> $past(ovf_i && !start_i && !restart_i && rep_cnt_o == '0));

  assert_load_no_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i || restart_i |=> !update_o);

  assert_update_sets_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> ue_flag_o);

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ue_flag_o && !ue_clr_i |=> ue_flag_o);

  assert_irq_needs_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ue_flag_o);

  assert_repok_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(repok_o) |-> $past(rep_wr_i, 2));

  assert_count_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_i && !start_i && !restart_i |=> $stable(rep_cnt_o));
endmodule

bind repeat_cnt repeat_cnt_chk #(.REP_W(REP_W)) i_repeat_cnt_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .restart_i   (restart_i),
  .ovf_i       (ovf_i),
  .rep_wr_i    (rep_wr_i),
  .ue_clr_i    (ue_clr_i),
  .rep_cnt_o   (rep_cnt_o),
  .update_o    (update_o),
  .ue_flag_o   (ue_flag_o),
  .irq_o       (irq_o),
  .repok_o     (repok_o)
);

// File: tb/test_repeat_cnt.sv
module test_repeat_cnt;
  localparam int unsigned REP_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             preload_i = 1'b0, start_i = 1'b0, restart_i = 1'b0, ovf_i = 1'b0;
  logic             rep_wr_i = 1'b0;
  logic [REP_W-1:0] rep_wdata_i = '0;
  logic             ue_clr_i = 1'b0, ue_ie_i = 1'b0, repok_clr_i = 1'b0;
  logic [REP_W-1:0] rep_cnt_o;
  logic             update_o, ue_flag_o, irq_o, repok_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  repeat_cnt #(.REP_W(REP_W)) i_repeat_cnt (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // one cycle with given strobes, sample at the following falling edge
  task automatic step(input bit ovf, input bit st, input bit rst_tmo);
    ovf_i = ovf; start_i = st; restart_i = rst_tmo;
    @(negedge clk_i);
    ovf_i = 1'b0; start_i = 1'b0; restart_i = 1'b0;
  endtask

  task automatic write_rep(input logic [REP_W-1:0] v);
    rep_wr_i = 1'b1; rep_wdata_i = v;
    @(negedge clk_i);
    rep_wr_i = 1'b0;
    @(negedge clk_i);
    chk_eq("R10 repok after write", int'(repok_o), 1);
    repok_clr_i = 1'b1;
    @(negedge clk_i);
    repok_clr_i = 1'b0;
    chk_eq("R10 repok cleared", int'(repok_o), 0);
  endtask

  task automatic t_reset();
    chk_eq("R1 count", int'(rep_cnt_o), 0);
    chk_eq("R1 update", int'(update_o), 0);
    chk_eq("R1 ue flag", int'(ue_flag_o), 0);
    chk_eq("R1 repok", int'(repok_o), 0);
    chk_eq("R1 irq", int'(irq_o), 0);
    step(0, 1, 0);
    chk_eq("R1 active reload zero", int'(rep_cnt_o), 0);
  endtask

  task automatic t_immediate();
    preload_i = 1'b0;
    write_rep(8'd3);
    step(0, 1, 0);
    chk_eq("R6 start loads new value", int'(rep_cnt_o), 3);
    for (int i = 2; i >= 0; i--) begin
      step(1, 0, 0);
      chk_eq("R2 decrement", int'(rep_cnt_o), i);
      chk_eq("R2 no update", int'(update_o), 0);
    end
    step(1, 0, 0);
    chk_eq("R3 update pulse", int'(update_o), 1);
    chk_eq("R3 reload", int'(rep_cnt_o), 3);
    chk_eq("R8 flag set", int'(ue_flag_o), 1);
    chk_eq("R9 irq masked", int'(irq_o), 0);
    step(0, 0, 0);
    chk_eq("R3 pulse one cycle", int'(update_o), 0);
    chk_eq("R8 flag sticky", int'(ue_flag_o), 1);
    ue_ie_i = 1'b1;
    #1;
    chk_eq("R9 irq enabled", int'(irq_o), 1);
    ue_clr_i = 1'b1;
    @(negedge clk_i);
    ue_clr_i = 1'b0;
    chk_eq("R8 flag cleared", int'(ue_flag_o), 0);
    chk_eq("R9 irq low", int'(irq_o), 0);
    ue_ie_i = 1'b0;
  endtask

  task automatic t_write_running();
    // count is 3, active 3; write 5 immediately
    write_rep(8'd5);
    chk_eq("R11 count held over write", int'(rep_cnt_o), 3);
    repeat (3) step(1, 0, 0);
    chk_eq("R2 down to zero", int'(rep_cnt_o), 0);
    step(1, 0, 0);
    chk_eq("R6 underflow loads new value", int'(rep_cnt_o), 5);
    chk_eq("R3 update", int'(update_o), 1);
  endtask

  task automatic t_preload();
    preload_i = 1'b1;
    write_rep(8'd7);
    chk_eq("R5 count unchanged", int'(rep_cnt_o), 5);
    step(0, 1, 0);
    chk_eq("R5 start uses old active", int'(rep_cnt_o), 5);
    repeat (5) step(1, 0, 0);
    chk_eq("R5 at zero", int'(rep_cnt_o), 0);
    step(1, 0, 0);
    chk_eq("R5 underflow loads pending", int'(rep_cnt_o), 7);
    chk_eq("R5 update", int'(update_o), 1);
    step(0, 1, 0);
    chk_eq("R5 pending now active", int'(rep_cnt_o), 7);
    preload_i = 1'b0;
  endtask

  task automatic t_zero();
    write_rep(8'd0);
    step(0, 1, 0);
    chk_eq("R4 start zero", int'(rep_cnt_o), 0);
    for (int i = 0; i < 3; i++) begin
      step(1, 0, 0);
      chk_eq("R4 update every overflow", int'(update_o), 1);
      chk_eq("R4 count stays zero", int'(rep_cnt_o), 0);
    end
  endtask

  task automatic t_restart();
    write_rep(8'd2);
    step(0, 1, 0);
    chk_eq("R7 start", int'(rep_cnt_o), 2);
    step(1, 0, 0);
    chk_eq("R2 dec", int'(rep_cnt_o), 1);
    step(1, 0, 1);
    chk_eq("R7 restart wins over overflow", int'(rep_cnt_o), 2);
    chk_eq("R7 no update on load", int'(update_o), 0);
    repeat (2) step(1, 0, 0);
    step(1, 1, 0);
    chk_eq("R7 start at zero no update", int'(update_o), 0);
    chk_eq("R7 start at zero loads", int'(rep_cnt_o), 2);
  endtask

  task automatic t_set_wins();
    ue_clr_i = 1'b1;
    @(negedge clk_i);
    chk_eq("R8 cleared", int'(ue_flag_o), 0);
    repeat (2) step(1, 0, 0);
    ue_clr_i = 1'b1;
    step(1, 0, 0);
    ue_clr_i = 1'b0;
    chk_eq("R8 set wins over clear", int'(ue_flag_o), 1);
    rep_wr_i = 1'b1; rep_wdata_i = 8'd4;
    @(negedge clk_i);
    rep_wr_i = 1'b0; repok_clr_i = 1'b1;
    @(negedge clk_i);
    repok_clr_i = 1'b0;
    chk_eq("R10 arrival wins over clear", int'(repok_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_immediate();
    t_write_running();
    t_preload();
    t_zero();
    t_restart();
    t_set_wins();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog: actual=0 expected=1");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule